// File: doc/BRIEF.md
# Rank-Based Ready Instruction Selector

This block sits between a pool of ready instructions and the execution pipelines. It picks at most one pool slot per cycle. Every slot carries a valid bit, a dispatch sequence number, a count of instructions that consume its result, and a mask of the resource units it needs. A second input reports which units are free this cycle.

The selector scores each eligible slot with a rank equal to its sequence number minus its consumer count. A slot whose result feeds many consumers can therefore move ahead of older work. The lowest rank wins. On equal ranks the older slot wins, and on equal sequence numbers the lower slot number wins. The selector also reports which units held back valid slots during the cycle.

A separate path turns any resource mask into the index of its highest set bit. Upstream logic uses this index to name a unit. Every output is registered, so each result appears one clock after the inputs that produced it.

Top module: `rank_pick`

## Requirements
- R1: A slot's rank is its sequence number minus its consumer count, computed as a signed value one bit wider than the sequence number. A consumer count larger than the sequence number gives a negative rank, and that rank beats every non-negative rank.
- R2: A slot is eligible only when its valid bit is 1 and every bit set in its need mask is also set in `res_free_i`. Invalid slots never win and never add to the busy mask.
- R3: Among eligible slots, the one with the lowest rank is picked.
- R4: On equal ranks, the slot with the smaller sequence number is picked. On equal rank and equal sequence number, the lower slot number is picked.
- R5: When no slot is eligible, `pick_vld_o` is 0 and `pick_slot_o` is 0.
- R6: `busy_res_o` is the OR, over all valid slots, of (need mask AND NOT `res_free_i`). It is recomputed from scratch every cycle and keeps no bits from earlier cycles.
- R7: `conv_id_o` is the bit position of the highest set bit of `conv_mask_i`, and `conv_vld_o` is 1 when that mask is non-zero. A zero mask gives `conv_vld_o` = 0 and `conv_id_o` = 0.
- R8: All outputs are registered and show the result for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld_i | input | NUM_SLOTS | Per-slot valid bits |
| slot_seq_i | input | NUM_SLOTS*SEQ_W | Per-slot dispatch sequence number; slot k at bits [k*SEQ_W +: SEQ_W] |
| slot_users_i | input | NUM_SLOTS*USR_W | Per-slot consumer count; slot k at bits [k*USR_W +: USR_W] |
| slot_need_i | input | NUM_SLOTS*RES_W | Per-slot required unit mask; slot k at bits [k*RES_W +: RES_W] |
| res_free_i | input | RES_W | Bit u is 1 when unit u is free this cycle |
| conv_mask_i | input | RES_W | Mask to convert into a unit index |
| pick_vld_o | output | 1 | A slot was picked |
| pick_slot_o | output | $clog2(NUM_SLOTS) | Picked slot number |
| busy_res_o | output | RES_W | Units that held back valid slots |
| conv_vld_o | output | 1 | `conv_mask_i` was non-zero |
| conv_id_o | output | $clog2(RES_W) | Index of the highest set bit of `conv_mask_i` |

## Verification
The bench goes after a consumer count larger than the sequence number. A rank kept at the sequence width would wrap to a large positive value, and the slot would lose to older work. It tests equal ranks with different ages and fully identical slots in two positions; a comparator with the wrong tie order or the wrong strictness would pick the younger or the higher slot. It checks that an invalid slot with a blocked need stays out of the busy mask, and that the busy mask drops to zero in the cycle after all units free up, since an accumulating mask would keep stale bits. For the conversion it uses masks with several bits set, which exposes a scan that stops at the lowest set bit.

// File: rtl/rank_pick_pkg.sv
package rank_pick_pkg;

    // Widest sequence number and slot number a candidate record can carry.
    localparam int SEQ_MAX  = 16;
    localparam int SLOT_MAX = 8;

    typedef struct packed {
        logic                      elig;
        logic signed [SEQ_MAX:0]   rank;
        logic        [SEQ_MAX-1:0] seq;
        logic        [SLOT_MAX-1:0] slot;
    } cand_t;

    // True when a must displace b. A tie on rank and sequence keeps b, so
    // putting the lower slot in b gives the lower slot the win.
    function automatic logic beats(input cand_t a, input cand_t b);
        if (!a.elig) return 1'b0;
        if (!b.elig) return 1'b1;
        if (a.rank != b.rank) return a.rank < b.rank;
        return a.seq < b.seq;
    endfunction

endpackage

// File: rtl/rank_pick_score.sv
module rank_pick_score
    import rank_pick_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SEQ_W     = 8,
    parameter int USR_W     = 4,
    parameter int RES_W     = 8
) (
    input  logic [NUM_SLOTS-1:0]       slot_vld_i,
    input  logic [NUM_SLOTS*SEQ_W-1:0] slot_seq_i,
    input  logic [NUM_SLOTS*USR_W-1:0] slot_users_i,
    input  logic [NUM_SLOTS*RES_W-1:0] slot_need_i,
    input  logic [RES_W-1:0]           res_free_i,
    output cand_t                      cands_o [NUM_SLOTS],
    output logic [RES_W-1:0]           busy_o
);
    localparam int RANK_W = SEQ_W + 1;

    logic [RES_W-1:0] miss_w [NUM_SLOTS];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        logic [SEQ_W-1:0]         seq_w;
        logic [USR_W-1:0]         usr_w;
        logic signed [RANK_W-1:0] rank_w;

        assign seq_w     = slot_seq_i[k*SEQ_W +: SEQ_W];
        assign usr_w     = slot_users_i[k*USR_W +: USR_W];
        assign miss_w[k] = slot_need_i[k*RES_W +: RES_W] & ~res_free_i;
        assign rank_w    = $signed(RANK_W'(seq_w)) - $signed(RANK_W'(usr_w));

        assign cands_o[k] = '{
            elig: slot_vld_i[k] && (miss_w[k] == '0),
            rank: (SEQ_MAX+1)'(rank_w),
            seq:  SEQ_MAX'(seq_w),
            slot: SLOT_MAX'(k)
        };
    end

    always_comb begin
        busy_o = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (slot_vld_i[k]) busy_o = busy_o | miss_w[k];
        end
    end

endmodule

// File: rtl/rank_pick_tree.sv
module rank_pick_tree
    import rank_pick_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input  cand_t cands_i [NUM_SLOTS],
    output cand_t win_o
);
    localparam int LVLS = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 0;
    localparam int PAD  = 1 << LVLS;

    always_comb begin
        cand_t work [PAD];
        for (int k = 0; k < PAD; k++) begin
            if (k < NUM_SLOTS) work[k] = cands_i[k];
            else               work[k] = '0;
        end
        // Pairwise rounds; the left node always holds the lower slots.
        for (int lv = 0; lv < LVLS; lv++) begin
            for (int k = 0; k < (PAD >> (lv + 1)); k++) begin
                work[k] = beats(work[2*k+1], work[2*k]) ? work[2*k+1] : work[2*k];
            end
        end
        win_o = work[0];
    end

endmodule

// File: rtl/rank_pick_msb.sv
module rank_pick_msb #(
    parameter int W = 8,
    localparam int IDW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]   mask_i,
    output logic [IDW-1:0] id_o,
    output logic           vld_o
);
    always_comb begin
        id_o  = '0;
        vld_o = |mask_i;
        for (int b = 0; b < W; b++) begin
            if (mask_i[b]) id_o = IDW'(b);
        end
    end

endmodule

// File: rtl/rank_pick.sv
module rank_pick
    import rank_pick_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SEQ_W     = 8,
    parameter int USR_W     = 4,
    parameter int RES_W     = 8,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int RID_W  = (RES_W > 1) ? $clog2(RES_W) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS-1:0]       slot_vld_i,
    input  logic [NUM_SLOTS*SEQ_W-1:0] slot_seq_i,
    input  logic [NUM_SLOTS*USR_W-1:0] slot_users_i,
    input  logic [NUM_SLOTS*RES_W-1:0] slot_need_i,
    input  logic [RES_W-1:0]           res_free_i,
    input  logic [RES_W-1:0]           conv_mask_i,
    output logic                       pick_vld_o,
    output logic [SLOT_W-1:0]          pick_slot_o,
    output logic [RES_W-1:0]           busy_res_o,
    output logic                       conv_vld_o,
    output logic [RID_W-1:0]           conv_id_o
);
    initial begin
        assert (SEQ_W <= SEQ_MAX && USR_W <= SEQ_W && SLOT_W <= SLOT_MAX)
            else $error("rank_pick: parameter exceeds candidate record widths");
    end

    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] slot;
        logic [RES_W-1:0]  busy;
        logic              cvld;
        logic [RID_W-1:0]  cid;
    } out_t;

    cand_t            cands_w [NUM_SLOTS];
    cand_t            win_w;
    logic [RES_W-1:0] busy_w;
    logic [RID_W-1:0] cid_w;
    logic             cvld_w;
    out_t             st_d, st_q;

    rank_pick_score #(
        .NUM_SLOTS(NUM_SLOTS), .SEQ_W(SEQ_W), .USR_W(USR_W), .RES_W(RES_W)
    ) u_score (
        .slot_vld_i   (slot_vld_i),
        .slot_seq_i   (slot_seq_i),
        .slot_users_i (slot_users_i),
        .slot_need_i  (slot_need_i),
        .res_free_i   (res_free_i),
        .cands_o      (cands_w),
        .busy_o       (busy_w)
    );

    rank_pick_tree #(.NUM_SLOTS(NUM_SLOTS)) u_tree (
        .cands_i (cands_w),
        .win_o   (win_w)
    );

    rank_pick_msb #(.W(RES_W)) u_msb (
        .mask_i (conv_mask_i),
        .id_o   (cid_w),
        .vld_o  (cvld_w)
    );

    always_comb begin
        st_d.vld  = win_w.elig;
        st_d.slot = win_w.elig ? SLOT_W'(win_w.slot) : '0;
        st_d.busy = busy_w;
        st_d.cvld = cvld_w;
        st_d.cid  = cid_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pick_vld_o  = st_q.vld;
    assign pick_slot_o = st_q.slot;
    assign busy_res_o  = st_q.busy;
    assign conv_vld_o  = st_q.cvld;
    assign conv_id_o   = st_q.cid;

    // R2: a reported pick was a valid slot in the sampled cycle
    a_r2_pick_was_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld_o |-> 1'($past(slot_vld_i) >> pick_slot_o));

    // R2: every unit the picked slot needed was free in that cycle
    a_r2_pick_units_free: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld_o |-> ((RES_W'($past(slot_need_i) >> (RES_W * 32'(pick_slot_o)))
                         & ~$past(res_free_i)) == '0));

    // R5: an empty pool never yields a pick
    a_r5_empty_no_pick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|slot_vld_i) |-> !pick_vld_o);

    // R6: busy units are never ones that were free
    a_r6_busy_not_free: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_res_o & $past(res_free_i)) == '0);

    // R7: the reported index is the top set bit of the sampled mask
    a_r7_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        conv_vld_o |-> (($past(conv_mask_i) >> conv_id_o) == RES_W'(1)));

    // R7: a zero mask gives no index
    a_r7_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|conv_mask_i) |-> !conv_vld_o);

endmodule

// File: tb/rank_pick_tb.sv
module rank_pick_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int SW = 8;
    localparam int UW = 4;
    localparam int RW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side pool image
    bit vld [N];
    int seq [N];
    int usr [N];
    int need[N];
    int free_m;
    int cmask;

    logic [N-1:0]    slot_vld_i;
    logic [N*SW-1:0] slot_seq_i;
    logic [N*UW-1:0] slot_users_i;
    logic [N*RW-1:0] slot_need_i;
    logic [RW-1:0]   res_free_i, conv_mask_i;
    logic            pick_vld_o, conv_vld_o;
    logic [3:0]      pick_slot_o;
    logic [RW-1:0]   busy_res_o;
    logic [2:0]      conv_id_o;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            slot_vld_i[k]             = vld[k];
            slot_seq_i[k*SW +: SW]    = SW'(seq[k]);
            slot_users_i[k*UW +: UW]  = UW'(usr[k]);
            slot_need_i[k*RW +: RW]   = RW'(need[k]);
        end
        res_free_i  = RW'(free_m);
        conv_mask_i = RW'(cmask);
    end

    rank_pick #(.NUM_SLOTS(N), .SEQ_W(SW), .USR_W(UW), .RES_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .slot_vld_i(slot_vld_i), .slot_seq_i(slot_seq_i),
        .slot_users_i(slot_users_i), .slot_need_i(slot_need_i),
        .res_free_i(res_free_i), .conv_mask_i(conv_mask_i),
        .pick_vld_o(pick_vld_o), .pick_slot_o(pick_slot_o),
        .busy_res_o(busy_res_o), .conv_vld_o(conv_vld_o), .conv_id_o(conv_id_o)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_pool();
        for (int k = 0; k < N; k++) begin
            vld[k] = 1'b0; seq[k] = 0; usr[k] = 0; need[k] = 0;
        end
        free_m = 'hFF;
        cmask  = 0;
    endtask

    task automatic put(input int k, input int s, input int u, input int nd);
        vld[k] = 1'b1; seq[k] = s; usr[k] = u; need[k] = nd;
    endtask

    // Behavioural reference: compute from the current pool, clock once, compare.
    task automatic step(input string tag);
        int  e_vld, e_slot, e_busy, e_cvld, e_cid, best_r, best_s, r, miss;
        e_vld = 0; e_slot = 0; e_busy = 0; best_r = 0; best_s = 0;
        for (int k = 0; k < N; k++) begin
            if (vld[k]) begin
                miss = need[k] & ~free_m & 'hFF;
                if (miss != 0) e_busy |= miss;
                else begin
                    r = seq[k] - usr[k];
                    if (e_vld == 0 || r < best_r || (r == best_r && seq[k] < best_s)) begin
                        e_vld = 1; e_slot = k; best_r = r; best_s = seq[k];
                    end
                end
            end
        end
        e_cvld = (cmask != 0) ? 1 : 0;
        e_cid  = 0;
        for (int b = 0; b < RW; b++) if (cmask[b]) e_cid = b;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R5 pick valid"}, int'(pick_vld_o), e_vld);
        check({tag, " R3 pick slot"},  int'(pick_slot_o), e_slot);
        check({tag, " R6 busy mask"},  int'(busy_res_o), e_busy);
        check({tag, " R7 conv valid"}, int'(conv_vld_o), e_cvld);
        check({tag, " R7 conv index"}, int'(conv_id_o), e_cid);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_pool();
        put(0, 1, 0, 0);
        cmask = 'h80;
        repeat (3) @(negedge clk);
        // R8: outputs held at zero in reset despite a pickable pool
        check("R8 reset pick valid", int'(pick_vld_o), 0);
        check("R8 reset conv valid", int'(conv_vld_o), 0);
        check("R8 reset busy", int'(busy_res_o), 0);
        rst_n = 1'b1;

        clear_pool();
        step("R5 empty pool");

        put(0, 3, 0, 'h01); put(1, 5, 4, 'h02);
        step("R3 consumers outrank age");

        put(2, 1, 15, 'h04);
        step("R1 negative rank wins");

        clear_pool();
        put(3, 6, 2, 0); put(5, 4, 0, 0);
        step("R4 equal rank older wins");

        clear_pool();
        put(9, 7, 1, 0); put(7, 7, 1, 0);
        step("R4 identical lower slot wins");

        clear_pool();
        put(0, 0, 0, 'h10); put(4, 9, 0, 'h01);
        free_m = 'hEF;
        step("R2 blocked best skipped");

        clear_pool();
        put(0, 0, 0, 'h03); put(1, 2, 0, 'h80);
        free_m = 0;
        step("R5 all blocked");

        free_m = 'hFF;
        step("R6 busy cleared next cycle");

        clear_pool();
        put(3, 0, 9, 'h40); vld[3] = 1'b0;
        put(6, 50, 0, 0);
        free_m = 'h0F;
        step("R2 invalid slot ignored");

        free_m = 0;
        step("R2 zero need always eligible");

        clear_pool();
        cmask = 0;    step("R7 zero mask");
        cmask = 'h01; step("R7 bit zero");
        cmask = 'h80; step("R7 top bit");
        cmask = 'h5A; step("R7 several bits");

        for (int c = 0; c < 400; c++) begin
            for (int k = 0; k < N; k++) begin
                vld[k]  = ($urandom % 3) != 0;
                seq[k]  = $urandom % 256;
                usr[k]  = $urandom % 16;
                need[k] = ($urandom & $urandom) % 256;
            end
            free_m = ($urandom | $urandom) % 256;
            cmask  = $urandom % 256;
            step("R1 R3 R4 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule